// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block produces one pulse-width modulated output from a clock that is first slowed by a fixed, non-power-of-two ratio. A 4-bit code picks the ratio from a sparse table. A period counter then steps once per slowed tick. The output sits at its active level for a programmed number of ticks at the start of every period, and at the inactive level for the rest.

Software configures the block through a small synchronous register port with two words. The control word holds the ratio code, a channel enable, a clock-gate enable, the active output level and a read-only busy flag. The period word holds the period field, stored as length minus one, and the active-tick count.

A period write is staged in a shadow copy and raises the busy flag. The working counters take the staged values at the next period boundary, or on the next clock if the channel is stopped, and the flag then drops. Software waits for the flag to clear before it changes the configuration again.

Top module: `prescaled_pwm`

## Requirements
- R1: The ratio code in control bits [3:0] sets the clock cycles per tick: 0xF gives 1; 0x0, 0x1, 0x2, 0x3 and 0x4 give 120, 180, 240, 360 and 480; 0x8, 0x9, 0xA, 0xB and 0xC give 12000, 24000, 36000, 48000 and 72000.
- R2: Codes 0x5, 0x6, 0x7, 0xD and 0xE produce no tick, so the output holds its inactive level and the period count stays at zero.
- R3: The channel runs only while control bit 4 (enable) and control bit 6 (gate) are both 1. Otherwise both counters are held at zero and the output is at the inactive level, so a restart begins a fresh period.
- R4: Control bit 5 is the active level. When it is 1 the output is high while active and low otherwise. When it is 0 both levels are inverted, and the inactive level is always the complement of bit 5.
- R5: One period lasts the value in period bits [31:16] plus one ticks.
- R6: The output is active for the first N ticks of each period, where N is period bits [15:0]. N = 0 keeps the output inactive. N greater than the period field keeps it active throughout.
- R7: A write to the period word sets control bit 28 (busy) on the same clock edge. Only a period write sets it.
- R8: Staged period values move into the working counters, and busy clears, at the clock edge that ends the current period while running, or on the next clock edge while stopped. Until then the output keeps the old timing.
- R9: Address 0x0 is the control word and 0x4 is the period word. A read of 0x0 returns bits 0 to 6 as written, the live busy flag in bit 28 and zero elsewhere. Bit 28 ignores writes. A read of 0x4 returns the last written period word.
- R10: After reset all fields are zero, busy is 0 and the output is high (the inactive level for active level 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W (4) | Word address: 0x0 control, 0x4 period |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: 16-bit count fields, a 17-bit prescaler counter and a 32-bit data word. The ratios are fixed, so the bench keeps the period fields small. That keeps whole periods at ratio 1 and 120, and a full period at ratio 12000, inside the run, and lets it check every sample at the first two ratios. The bench also measures the exact cycle at which a staged period takes effect on a running channel, and it checks the unused-code stall, the gate stall and both polarities.

// File: rtl/pwm_pkg.sv
// Shared constants and the ratio-code decoder for the prescaled PWM block.
// Assumes a 4-bit ratio code; an unused code decodes to ratio 0.
package pwm_pkg;
    localparam int CTL_CODE_W = 4;
    localparam int CTL_EN_BIT   = 4;
    localparam int CTL_LVL_BIT  = 5;
    localparam int CTL_GATE_BIT = 6;
    localparam int CTL_BUSY_BIT = 28;
    localparam int ADDR_CTL = 0;
    localparam int ADDR_PER = 4;

    // Map a ratio code to clock cycles per tick; 0 means the code is unused.
    function automatic int unsigned ratio_of(input logic [CTL_CODE_W-1:0] code);
        unique case (code)
            4'hF: ratio_of = 1;
            4'h0: ratio_of = 120;
            4'h1: ratio_of = 180;
            4'h2: ratio_of = 240;
            4'h3: ratio_of = 360;
            4'h4: ratio_of = 480;
            4'h8: ratio_of = 12000;
            4'h9: ratio_of = 24000;
            4'hA: ratio_of = 36000;
            4'hB: ratio_of = 48000;
            4'hC: ratio_of = 72000;
            default: ratio_of = 0;
        endcase
    endfunction
endpackage

// File: rtl/pwm_regs.sv
// Register file of the PWM block: control fields, staged period word and
// the busy flag. Assumes DATA_W >= 2*CNT_W. Reads are combinational.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  load_done,
    output logic [CTL_CODE_W-1:0] code,
    output logic                  en,
    output logic                  lvl,
    output logic                  gate,
    output logic [CNT_W-1:0]      stage_per,
    output logic [CNT_W-1:0]      stage_act,
    output logic                  busy,
    output logic [DATA_W-1:0]     rdata
);
    logic sel_ctl, sel_per;
    assign sel_ctl = (addr == ADDR_W'(ADDR_CTL));
    assign sel_per = (addr == ADDR_W'(ADDR_PER));

    // Control fields: loaded by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            en   <= 1'b0;
            lvl  <= 1'b0;
            gate <= 1'b0;
        end else if (wr_en && sel_ctl) begin
            code <= wdata[CTL_CODE_W-1:0];
            en   <= wdata[CTL_EN_BIT];
            lvl  <= wdata[CTL_LVL_BIT];
            gate <= wdata[CTL_GATE_BIT];
        end
    end

    // Staged period word: loaded by a period write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_per <= '0;
            stage_act <= '0;
        end else if (wr_en && sel_per) begin
            stage_per <= wdata[2*CNT_W-1:CNT_W];
            stage_act <= wdata[CNT_W-1:0];
        end
    end

    // Busy flag: set by a period write, cleared when the counters take it.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy <= 1'b0;
        else if (wr_en && sel_per) busy <= 1'b1;
        else if (load_done)        busy <= 1'b0;
    end

    // Read mux: control word with live busy, or the staged period word.
    always_comb begin
        rdata = '0;
        if (sel_ctl) begin
            rdata[CTL_CODE_W-1:0] = code;
            rdata[CTL_EN_BIT]     = en;
            rdata[CTL_LVL_BIT]    = lvl;
            rdata[CTL_GATE_BIT]   = gate;
            rdata[CTL_BUSY_BIT]   = busy;
        end else if (sel_per) begin
            rdata[2*CNT_W-1:0] = {stage_per, stage_act};
        end
    end

    // R7: a period write raises busy on the next cycle.
    a_r7_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_per) |=> busy);
    // R9: busy cannot be set through any path other than a period write.
    a_r9_busy_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_en && sel_per)) |=> !busy);
endmodule

// File: rtl/pwm_prescaler.sv
// Divides the clock by the ratio the code selects and emits a one-cycle
// tick per ratio cycles. Held at zero while stopped or on an unused code.
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int PRE_W = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [CTL_CODE_W-1:0] code,
    output logic                  tick,
    output logic                  valid
);
    logic [PRE_W-1:0] ratio;
    logic [PRE_W-1:0] pcnt;
    logic             last;

    assign ratio = PRE_W'(ratio_of(code));
    assign valid = (ratio != '0);
    assign last  = valid && (pcnt >= ratio - PRE_W'(1));
    assign tick  = run && last;

    // Prescale counter: counts 0..ratio-1, cleared when idle or invalid.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !valid) pcnt <= '0;
        else if (last)                pcnt <= '0;
        else                          pcnt <= pcnt + PRE_W'(1);
    end

    // R1: with a ratio above one, a tick is never followed by another
    // unless the code changed in between.
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio > PRE_W'(1)) |=> (!tick || code != $past(code)));
    // R2: an unused code yields no tick.
    a_r2_unused_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_of(code) == 0) |-> !tick);
endmodule

// File: rtl/pwm_period.sv
// Period counter, working copy of the period word, and output stage.
// Takes staged values at a period end while running, or at once when
// stopped. Assumes tick is a one-cycle pulse.
module pwm_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             valid,
    input  logic             tick,
    input  logic             lvl,
    input  logic             busy,
    input  logic [CNT_W-1:0] stage_per,
    input  logic [CNT_W-1:0] stage_act,
    output logic             load_done,
    output logic             pwm_out
);
    logic [CNT_W-1:0] work_per;
    logic [CNT_W-1:0] work_act;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             active;

    assign wrap      = tick && (cnt >= work_per);
    assign load_done = busy && (!run || wrap);
    assign active    = run && valid && (cnt < work_act);
    assign pwm_out   = active ? lvl : !lvl;

    // Working period and active count: updated only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_per <= '0;
            work_act <= '0;
        end else if (load_done) begin
            work_per <= stage_per;
            work_act <= stage_act;
        end
    end

    // Period counter: steps per tick, wraps after work_per, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (tick)      cnt <= cnt + CNT_W'(1);
    end

    // R5: the count never passes the period field.
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= work_per);
    // R8: while a load is pending on a running channel, the timing holds.
    a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run && !wrap) |=> ($stable(work_per) && $stable(work_act)));
    // R8: a load on a running channel starts a fresh period.
    a_r8_load_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && run) |=> (cnt == '0));
    // R3: a stopped channel drives the inactive level.
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == !lvl));
endmodule

// File: rtl/prescaled_pwm.sv
// Top of the prescaled single-channel PWM block: register port, prescaler
// and period stage. Assumes DATA_W >= 2*CNT_W and PRE_W wide enough for
// the largest ratio (72000).
module prescaled_pwm
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int PRE_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    logic [CTL_CODE_W-1:0] code;
    logic                  en, lvl, gate, busy, load_done, tick, valid, run;
    logic [CNT_W-1:0]      stage_per, stage_act;

    assign run = en && gate;

    pwm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .load_done(load_done), .code(code), .en(en),
        .lvl(lvl), .gate(gate), .stage_per(stage_per),
        .stage_act(stage_act), .busy(busy), .rdata(reg_rdata)
    );

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .code(code),
        .tick(tick), .valid(valid)
    );

    pwm_period #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .run(run), .valid(valid), .tick(tick),
        .lvl(lvl), .busy(busy), .stage_per(stage_per),
        .stage_act(stage_act), .load_done(load_done), .pwm_out(pwm_out)
    );
endmodule

// File: tb/sim_prescaled_pwm.sv
`timescale 1ns/1ps
module sim_prescaled_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    prescaled_pwm u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    localparam logic [31:0] EN = 32'h10, LVL = 32'h20, GATE = 32'h40;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic exp_out(int k, int r, int per, int act, logic lv);
        int c = (k / r) % (per + 1);
        return (c < act) ? lv : !lv;
    endfunction

    // Stop, stage a period word, then start with the given control word.
    task automatic setup(input int per, input int act, input logic [31:0] ctl);
        wr(4'h0, 32'h0);
        wr(4'h4, {per[15:0], act[15:0]});
        wr(4'h0, ctl);
    endtask

    // Sample n cycles from the cycle right after the start edge.
    task automatic pattern(input int n, input int r, input int per, input int act,
                           input logic lv, input string tag);
        for (int k = 0; k < n; k++) begin
            chk({31'b0, pwm_out}, {31'b0, exp_out(k, r, per, act, lv)}, tag);
            if (k < n - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk({31'b0, pwm_out}, 32'h1, "R10 reset output high");
        rd(4'h0, d); chk(d, 32'h0, "R10 reset control");
        rd(4'h4, d); chk(d, 32'h0, "R10 reset period");
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d); chk(d, 32'h0000_007F, "R9 control readback, bit28 ignores write");
        wr(4'h0, 32'h0);
        rd(4'h0, d); chk(d, 32'h0, "R9 control cleared");
        wr(4'h4, 32'h1234_5678);
        rd(4'h4, d); chk(d, 32'h1234_5678, "R9 period readback");
    endtask

    task automatic t_immediate_load;
        logic [31:0] d;
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0004_0002);
        rd(4'h0, d); chk(d[28], 1'b1, "R7 busy set after period write");
        @(negedge clk);
        rd(4'h0, d); chk(d[28], 1'b0, "R8 busy clears one cycle later while stopped");
    endtask

    task automatic t_basic;
        setup(4, 2, EN | GATE | LVL | 32'hF);
        pattern(15, 1, 4, 2, 1'b1, "R5 R6 R1 ratio 1 high-active");
    endtask

    task automatic t_polarity;
        setup(4, 2, EN | GATE | 32'hF);
        pattern(10, 1, 4, 2, 1'b0, "R4 inverted polarity");
    endtask

    task automatic t_act_edges;
        setup(4, 0, EN | GATE | LVL | 32'hF);
        pattern(10, 1, 4, 0, 1'b1, "R6 zero active count");
        setup(4, 5, EN | GATE | LVL | 32'hF);
        pattern(10, 1, 4, 5, 1'b1, "R6 full active count");
    endtask

    task automatic t_gate;
        setup(3, 2, EN | LVL | 32'hF);
        for (int k = 0; k < 8; k++) begin
            chk({31'b0, pwm_out}, 32'h0, "R3 enable without gate stays inactive");
            @(negedge clk);
        end
        wr(4'h0, GATE | LVL | 32'hF);
        for (int k = 0; k < 8; k++) begin
            chk({31'b0, pwm_out}, 32'h0, "R3 gate without enable stays inactive");
            @(negedge clk);
        end
        wr(4'h0, EN | GATE | LVL | 32'hF);
        pattern(8, 1, 3, 2, 1'b1, "R3 restart begins fresh period");
    endtask

    task automatic t_unused;
        setup(3, 2, EN | GATE | LVL | 32'h5);
        for (int k = 0; k < 20; k++) begin
            chk({31'b0, pwm_out}, 32'h0, "R2 unused code holds inactive");
            @(negedge clk);
        end
        wr(4'h0, EN | GATE | LVL | 32'hF);
        pattern(8, 1, 3, 2, 1'b1, "R2 count stayed at zero on unused code");
    endtask

    task automatic t_div120;
        setup(1, 1, EN | GATE | LVL | 32'h0);
        pattern(480, 120, 1, 1, 1'b1, "R1 ratio 120");
    endtask

    task automatic t_div12000;
        setup(1, 1, EN | GATE | LVL | 32'h8);
        chk({31'b0, pwm_out}, 32'h1, "R1 ratio 12000 start active");
        repeat (11999) @(negedge clk);
        chk({31'b0, pwm_out}, 32'h1, "R1 ratio 12000 last active cycle");
        @(negedge clk);
        chk({31'b0, pwm_out}, 32'h0, "R1 ratio 12000 first inactive cycle");
        repeat (11999) @(negedge clk);
        chk({31'b0, pwm_out}, 32'h0, "R1 ratio 12000 last inactive cycle");
        @(negedge clk);
        chk({31'b0, pwm_out}, 32'h1, "R1 ratio 12000 next period");
    endtask

    task automatic t_running_update;
        logic [31:0] d;
        int waited;
        setup(4, 2, EN | GATE | LVL | 32'hF);
        wr(4'h4, 32'h0002_0001);
        rd(4'h0, d); chk(d[28], 1'b1, "R7 busy set on running channel");
        chk({31'b0, pwm_out}, 32'h0, "R8 old timing kept while pending");
        waited = 0;
        while (d[28] && waited < 20) begin
            @(negedge clk);
            waited++;
            rd(4'h0, d);
        end
        chk(waited, 3, "R8 load waits for period end");
        pattern(9, 1, 2, 1, 1'b1, "R8 new timing after load");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_immediate_load();
        t_basic();
        t_polarity();
        t_act_edges();
        t_gate();
        t_unused();
        t_running_update();
        t_div120();
        t_div12000();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule